// File: doc/BRIEF.md
# Ring Queue Pointer and Doorbell Manager

This block holds the pointer state for a small set of paired ring queues in a storage-controller register space. Each pair has a submission ring, which the host fills and the controller drains, and a completion ring, which the controller fills and the host drains. The host moves its side of each ring by writing 32-bit doorbell registers. The block decodes those writes by address into submission-tail or completion-head updates. A fetch engine steps a submission head with one pulse per command it takes. A completion engine posts results into a completion ring. The block returns the slot index and the completion status word, which carries the ring's phase tag.

A configure port creates or deletes a queue. It sets the queue's size from a zero-based count, binds a submission ring to a completion ring, and enables interrupts for a completion ring. Queue 0 is the admin pair, and it is configured in the same way as the others. The block emits two kinds of one-cycle request. An interrupt request goes out for each completion ring. A restart request goes out for each submission ring whose completion ring was full and has just been freed by the host.

Top module: `qdb_ring_mgr`

## Requirements
- R1: After reset every queue is invalid, and every head, tail and phase bit is 0. `sq_empty_o` is all ones, and `cq_full_o`, `irq_req_o`, `restart_o` and `cpl_valid_o` are all zero.
- R2: A create command (`cfg_op_i`=1) with zero-based size n≠0 makes the queue valid with size n+1 and clears its head and tail. A completion ring also takes phase 1 and the interrupt enable from `cfg_ien_i`. A create is rejected, leaving the queue unchanged, when n=0, or for a submission ring whose bound completion ring (`cfg_bind_i`) is invalid.
- R3: An aligned doorbell write to byte address 0x1000+8·q updates the tail of submission ring q. A write to 0x1000+8·q+4 updates the head of completion ring q. The new pointer value is `db_wdata_i[15:0]`, and the upper data bits are ignored.
- R4: A doorbell write whose address has bits [1:0] ≠ 0 changes no pointer.
- R5: A doorbell write is ignored in three cases: its address is below 0x1000, its address is at or above 0x1000+8·NQ, or its value is greater than or equal to the target queue's size.
- R6: A submission ring is empty when head equals tail. A fetch pulse advances the head by one modulo the size, and a fetch on an empty or invalid ring is ignored.
- R7: A completion ring is full when (tail+1) mod size equals head. A post to a full or invalid ring is dropped, and `cpl_valid_o` stays low.
- R8: An accepted post advances the completion tail by one. When the tail wraps from size−1 to 0, the phase bit inverts.
- R9: One cycle after an accepted post, `cpl_valid_o` pulses. `cpl_word_o` = {status, phase before the post}, `cpl_slot_o` = tail before the post, and `cpl_sqid_o` and `cpl_sqhead_o` give the named submission ring and its current head.
- R10: When an accepted completion-head doorbell hits a ring that was full, `restart_o` pulses one cycle later for every valid submission ring bound to it.
- R11: When an accepted completion-head doorbell leaves tail ≠ new head on a ring with interrupts enabled, that ring's `irq_req_o` bit pulses one cycle later.
- R12: A delete command (`cfg_op_i`=0) makes the queue invalid, after which its doorbells are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| db_we_i | input | 1 | Doorbell write strobe |
| db_addr_i | input | 16 | Doorbell byte address |
| db_wdata_i | input | 32 | Doorbell write data |
| cfg_we_i | input | 1 | Configure strobe |
| cfg_op_i | input | 1 | 1 create, 0 delete |
| cfg_cq_i | input | 1 | 1 targets completion ring, 0 submission ring |
| cfg_qid_i | input | 3 | Queue id to configure |
| cfg_zsize_i | input | 16 | Zero-based queue size |
| cfg_ien_i | input | 1 | Interrupt enable for a created completion ring |
| cfg_bind_i | input | 3 | Completion ring bound to a created submission ring |
| sq_fetch_i | input | 8 | Per-ring submission head advance pulses |
| cpl_post_i | input | 1 | Completion post strobe |
| cpl_cqid_i | input | 3 | Target completion ring |
| cpl_sqid_i | input | 3 | Submission ring the completion belongs to |
| cpl_status_i | input | 15 | Completion status code |
| cpl_valid_o | output | 1 | Accepted completion, one-cycle pulse |
| cpl_word_o | output | 16 | Status shifted left with phase in bit 0 |
| cpl_slot_o | output | 16 | Completion slot index used |
| cpl_sqid_o | output | 3 | Submission ring id of the completion |
| cpl_sqhead_o | output | 16 | Head of that submission ring |
| sq_empty_o | output | 8 | Per-ring submission empty flags |
| cq_full_o | output | 8 | Per-ring completion full flags |
| cq_phase_o | output | 8 | Per-ring completion phase bits |
| sq_head_o | output | 128 | Submission heads, 16 bits per ring, ring q at [16q+:16] |
| sq_tail_o | output | 128 | Submission tails, packed likewise |
| cq_head_o | output | 128 | Completion heads, packed likewise |
| cq_tail_o | output | 128 | Completion tails, packed likewise |
| irq_req_o | output | 8 | Per-ring interrupt request pulses |
| restart_o | output | 8 | Per-submission-ring restart pulses |

## Verification
For ring sizes 2 to 5, the bench fills a completion ring, drains it and wraps it several times. It predicts tail, phase, the full flag and the posted word by modular arithmetic. A design that inverts phase at the wrong point, or that counts a ring as full one slot early or late, posts wrong words or drops good posts. The doorbell decode is swept over all eight pairs, and the edge addresses are probed: misaligned, below the region, and one slot past it. A decoder that masks the queue index or drops the alignment test would then corrupt queue 0. A freed full ring must wake every bound submission ring, including one bound across pairs, and only rings with interrupts enabled may raise an interrupt. Creates with size 0, or bound to a deleted ring, must leave the pointers untouched.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam logic [15:0] DB_BASE    = 16'h1000;
  localparam logic        CFG_CREATE = 1'b1;
  localparam logic        CFG_DELETE = 1'b0;
endpackage

// File: rtl/qdb_decode.sv
module qdb_decode #(
  parameter int NQ     = 8,
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 16
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       data_i,
  output logic [NQ-1:0]     sq_we_o,
  output logic [NQ-1:0]     cq_we_o,
  output logic [PTR_W-1:0]  val_o
);
  localparam int SLOT_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(qdb_pkg::DB_BASE);

  logic [ADDR_W-1:0] off;
  logic [SLOT_W-1:0] slot;
  logic              hit;
  logic              unused_bits;

  assign off  = addr_i - BASE;
  assign slot = off[ADDR_W-1:3];
  assign hit  = we_i && (addr_i >= BASE) && (addr_i[1:0] == 2'b00) &&
                (slot < SLOT_W'(NQ));

  always_comb begin
    sq_we_o = '0;
    cq_we_o = '0;
    for (int q = 0; q < NQ; q++) begin
      if (hit && slot == SLOT_W'(q)) begin
        if (off[2]) cq_we_o[q] = 1'b1;
        else        sq_we_o[q] = 1'b1;
      end
    end
  end

  assign val_o       = data_i[PTR_W-1:0];
  assign unused_bits = ^{data_i[31:PTR_W], off[1:0]};
endmodule

// File: rtl/qdb_sq_ring.sv
module qdb_sq_ring #(
  parameter int PTR_W = 16,
  parameter int QID_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_set_i,
  input  logic             cfg_clr_i,
  input  logic [PTR_W-1:0] cfg_zsize_i,
  input  logic [QID_W-1:0] cfg_bind_i,
  input  logic             db_we_i,
  input  logic [PTR_W-1:0] db_val_i,
  input  logic             fetch_i,
  output logic             valid_o,
  output logic             empty_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [QID_W-1:0] bind_o
);
  localparam int SZ_W = PTR_W + 1;

  logic             valid_q;
  logic [SZ_W-1:0]  size_q;
  logic [PTR_W-1:0] head_q, tail_q, head_nxt;
  logic [QID_W-1:0] bind_q;
  logic             db_ok, fetch_ok, busy_cfg;

  assign busy_cfg = cfg_set_i || cfg_clr_i;
  assign db_ok    = !busy_cfg && valid_q && db_we_i && ({1'b0, db_val_i} < size_q);
  assign fetch_ok = !busy_cfg && valid_q && fetch_i && (head_q != tail_q);
  assign head_nxt = (({1'b0, head_q} + SZ_W'(1)) == size_q) ? '0 : head_q + PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      size_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      bind_q  <= '0;
    end else if (cfg_set_i) begin
      valid_q <= 1'b1;
      size_q  <= {1'b0, cfg_zsize_i} + SZ_W'(1);
      head_q  <= '0;
      tail_q  <= '0;
      bind_q  <= cfg_bind_i;
    end else if (cfg_clr_i) begin
      valid_q <= 1'b0;
    end else begin
      if (db_ok)    tail_q <= db_val_i;
      if (fetch_ok) head_q <= head_nxt;
    end
  end

  assign valid_o = valid_q;
  assign empty_o = (head_q == tail_q);
  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign bind_o  = bind_q;
endmodule

// File: rtl/qdb_cq_ring.sv
module qdb_cq_ring #(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_set_i,
  input  logic             cfg_clr_i,
  input  logic [PTR_W-1:0] cfg_zsize_i,
  input  logic             cfg_ien_i,
  input  logic             db_we_i,
  input  logic [PTR_W-1:0] db_val_i,
  input  logic             post_i,
  output logic             valid_o,
  output logic             full_o,
  output logic             phase_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             post_ok_o,
  output logic             wake_o,
  output logic             irq_o
);
  localparam int SZ_W = PTR_W + 1;

  logic             valid_q, phase_q, ien_q;
  logic [SZ_W-1:0]  size_q;
  logic [PTR_W-1:0] head_q, tail_q, tail_nxt;
  logic             wrap, full, db_ok, busy_cfg;

  assign busy_cfg  = cfg_set_i || cfg_clr_i;
  assign wrap      = (({1'b0, tail_q} + SZ_W'(1)) == size_q);
  assign tail_nxt  = wrap ? '0 : tail_q + PTR_W'(1);
  assign full      = valid_q && (tail_nxt == head_q);
  assign db_ok     = !busy_cfg && valid_q && db_we_i && ({1'b0, db_val_i} < size_q);
  assign post_ok_o = !busy_cfg && valid_q && post_i && !full;
  assign wake_o    = db_ok && full;
  assign irq_o     = db_ok && ien_q && (tail_q != db_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      phase_q <= 1'b0;
      ien_q   <= 1'b0;
      size_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else if (cfg_set_i) begin
      valid_q <= 1'b1;
      phase_q <= 1'b1;
      ien_q   <= cfg_ien_i;
      size_q  <= {1'b0, cfg_zsize_i} + SZ_W'(1);
      head_q  <= '0;
      tail_q  <= '0;
    end else if (cfg_clr_i) begin
      valid_q <= 1'b0;
    end else begin
      if (db_ok) head_q <= db_val_i;
      if (post_ok_o) begin
        tail_q <= tail_nxt;
        if (wrap) phase_q <= ~phase_q;
      end
    end
  end

  assign valid_o = valid_q;
  assign full_o  = full;
  assign phase_o = phase_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;
endmodule

// File: rtl/qdb_ring_mgr.sv
module qdb_ring_mgr #(
  parameter int NQ     = 8,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16,
  parameter int STAT_W = 15,
  localparam int QID_W = $clog2(NQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                db_we_i,
  input  logic [ADDR_W-1:0]   db_addr_i,
  input  logic [31:0]         db_wdata_i,
  input  logic                cfg_we_i,
  input  logic                cfg_op_i,
  input  logic                cfg_cq_i,
  input  logic [QID_W-1:0]    cfg_qid_i,
  input  logic [PTR_W-1:0]    cfg_zsize_i,
  input  logic                cfg_ien_i,
  input  logic [QID_W-1:0]    cfg_bind_i,
  input  logic [NQ-1:0]       sq_fetch_i,
  input  logic                cpl_post_i,
  input  logic [QID_W-1:0]    cpl_cqid_i,
  input  logic [QID_W-1:0]    cpl_sqid_i,
  input  logic [STAT_W-1:0]   cpl_status_i,
  output logic                cpl_valid_o,
  output logic [STAT_W:0]     cpl_word_o,
  output logic [PTR_W-1:0]    cpl_slot_o,
  output logic [QID_W-1:0]    cpl_sqid_o,
  output logic [PTR_W-1:0]    cpl_sqhead_o,
  output logic [NQ-1:0]       sq_empty_o,
  output logic [NQ-1:0]       cq_full_o,
  output logic [NQ-1:0]       cq_phase_o,
  output logic [NQ*PTR_W-1:0] sq_head_o,
  output logic [NQ*PTR_W-1:0] sq_tail_o,
  output logic [NQ*PTR_W-1:0] cq_head_o,
  output logic [NQ*PTR_W-1:0] cq_tail_o,
  output logic [NQ-1:0]       irq_req_o,
  output logic [NQ-1:0]       restart_o
);
  logic [NQ-1:0]    sq_db_we, cq_db_we;
  logic [PTR_W-1:0] db_val;
  logic [NQ-1:0]    sq_valid, cq_valid, cq_post_ok, cq_wake, cq_irq;
  logic [NQ-1:0]    sq_set, sq_clr, cq_set, cq_clr, cq_post;
  logic [PTR_W-1:0] sq_head [NQ];
  logic [PTR_W-1:0] sq_tail [NQ];
  logic [PTR_W-1:0] cq_head [NQ];
  logic [PTR_W-1:0] cq_tail [NQ];
  logic [QID_W-1:0] sq_bind [NQ];
  logic [NQ-1:0]    restart_d;
  logic             create_ok, delete_go, bind_ok;

  qdb_decode #(.NQ(NQ), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_decode (
    .we_i    (db_we_i),
    .addr_i  (db_addr_i),
    .data_i  (db_wdata_i),
    .sq_we_o (sq_db_we),
    .cq_we_o (cq_db_we),
    .val_o   (db_val)
  );

  assign bind_ok   = (32'(cfg_bind_i) < NQ) && cq_valid[cfg_bind_i];
  assign create_ok = cfg_we_i && (cfg_op_i == qdb_pkg::CFG_CREATE) &&
                     (cfg_zsize_i != '0) && (cfg_cq_i || bind_ok);
  assign delete_go = cfg_we_i && (cfg_op_i == qdb_pkg::CFG_DELETE);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign sq_set[q]  = create_ok && !cfg_cq_i && (cfg_qid_i == QID_W'(q));
    assign sq_clr[q]  = delete_go && !cfg_cq_i && (cfg_qid_i == QID_W'(q));
    assign cq_set[q]  = create_ok &&  cfg_cq_i && (cfg_qid_i == QID_W'(q));
    assign cq_clr[q]  = delete_go &&  cfg_cq_i && (cfg_qid_i == QID_W'(q));
    assign cq_post[q] = cpl_post_i && (cpl_cqid_i == QID_W'(q));

    qdb_sq_ring #(.PTR_W(PTR_W), .QID_W(QID_W)) u_sq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_set_i   (sq_set[q]),
      .cfg_clr_i   (sq_clr[q]),
      .cfg_zsize_i (cfg_zsize_i),
      .cfg_bind_i  (cfg_bind_i),
      .db_we_i     (sq_db_we[q]),
      .db_val_i    (db_val),
      .fetch_i     (sq_fetch_i[q]),
      .valid_o     (sq_valid[q]),
      .empty_o     (sq_empty_o[q]),
      .head_o      (sq_head[q]),
      .tail_o      (sq_tail[q]),
      .bind_o      (sq_bind[q])
    );

    qdb_cq_ring #(.PTR_W(PTR_W)) u_cq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_set_i   (cq_set[q]),
      .cfg_clr_i   (cq_clr[q]),
      .cfg_zsize_i (cfg_zsize_i),
      .cfg_ien_i   (cfg_ien_i),
      .db_we_i     (cq_db_we[q]),
      .db_val_i    (db_val),
      .post_i      (cq_post[q]),
      .valid_o     (cq_valid[q]),
      .full_o      (cq_full_o[q]),
      .phase_o     (cq_phase_o[q]),
      .head_o      (cq_head[q]),
      .tail_o      (cq_tail[q]),
      .post_ok_o   (cq_post_ok[q]),
      .wake_o      (cq_wake[q]),
      .irq_o       (cq_irq[q])
    );

    assign restart_d[q] = sq_valid[q] && cq_wake[sq_bind[q]];

    assign sq_head_o[q*PTR_W +: PTR_W] = sq_head[q];
    assign sq_tail_o[q*PTR_W +: PTR_W] = sq_tail[q];
    assign cq_head_o[q*PTR_W +: PTR_W] = cq_head[q];
    assign cq_tail_o[q*PTR_W +: PTR_W] = cq_tail[q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_valid_o  <= 1'b0;
      cpl_word_o   <= '0;
      cpl_slot_o   <= '0;
      cpl_sqid_o   <= '0;
      cpl_sqhead_o <= '0;
      irq_req_o    <= '0;
      restart_o    <= '0;
    end else begin
      cpl_valid_o <= |cq_post_ok;
      if (|cq_post_ok) begin
        cpl_word_o   <= {cpl_status_i, cq_phase_o[cpl_cqid_i]};
        cpl_slot_o   <= cq_tail[cpl_cqid_i];
        cpl_sqid_o   <= cpl_sqid_i;
        cpl_sqhead_o <= sq_head[cpl_sqid_i];
      end
      irq_req_o <= cq_irq;
      restart_o <= restart_d;
    end
  end
endmodule

// File: rtl/qdb_ring_mgr_chk.sv
module qdb_ring_mgr_chk #(
  parameter int NQ     = 8,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16,
  localparam int QID_W = $clog2(NQ)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                db_we_i,
  input logic [ADDR_W-1:0]   db_addr_i,
  input logic                cfg_we_i,
  input logic                cfg_op_i,
  input logic                cfg_cq_i,
  input logic [QID_W-1:0]    cfg_qid_i,
  input logic [PTR_W-1:0]    cfg_zsize_i,
  input logic                cpl_post_i,
  input logic                cpl_valid_o,
  input logic [NQ-1:0]       cq_phase_o,
  input logic [NQ*PTR_W-1:0] sq_tail_o,
  input logic [NQ*PTR_W-1:0] cq_head_o,
  input logic [NQ-1:0]       irq_req_o,
  input logic [NQ-1:0]       restart_o
);
  AST_CPL_NEEDS_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> $past(cpl_post_i)); // R9

  AST_RESTART_NEEDS_DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o != '0) |-> $past(db_we_i)); // R10

  AST_IRQ_NEEDS_DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o != '0) |-> $past(db_we_i)); // R11

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_req_o)); // R11

  AST_MISALIGN_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_we_i && db_addr_i[1:0] != 2'b00 && !cfg_we_i) |=>
      ($stable(sq_tail_o) && $stable(cq_head_o))); // R4

  AST_CQ_CREATE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_op_i && cfg_cq_i && cfg_zsize_i != '0) |=>
      cq_phase_o[$past(cfg_qid_i)]); // R2
endmodule

bind qdb_ring_mgr qdb_ring_mgr_chk #(.NQ(NQ), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/qdb_ring_mgr_tb.sv
module qdb_ring_mgr_tb;
  localparam int NQ = 8;
  localparam int PW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic db_we_i = 1'b0;
  logic [15:0] db_addr_i = '0;
  logic [31:0] db_wdata_i = '0;
  logic cfg_we_i = 1'b0, cfg_op_i = 1'b0, cfg_cq_i = 1'b0, cfg_ien_i = 1'b0;
  logic [2:0] cfg_qid_i = '0, cfg_bind_i = '0;
  logic [15:0] cfg_zsize_i = '0;
  logic [NQ-1:0] sq_fetch_i = '0;
  logic cpl_post_i = 1'b0;
  logic [2:0] cpl_cqid_i = '0, cpl_sqid_i = '0;
  logic [14:0] cpl_status_i = '0;
  logic cpl_valid_o;
  logic [15:0] cpl_word_o, cpl_slot_o, cpl_sqhead_o;
  logic [2:0] cpl_sqid_o;
  logic [NQ-1:0] sq_empty_o, cq_full_o, cq_phase_o, irq_req_o, restart_o;
  logic [NQ*PW-1:0] sq_head_o, sq_tail_o, cq_head_o, cq_tail_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  qdb_ring_mgr u_dut (.*);

  function automatic logic [15:0] sqh(int q); return sq_head_o[q*PW +: PW]; endfunction
  function automatic logic [15:0] sqt(int q); return sq_tail_o[q*PW +: PW]; endfunction
  function automatic logic [15:0] cqh(int q); return cq_head_o[q*PW +: PW]; endfunction
  function automatic logic [15:0] cqt(int q); return cq_tail_o[q*PW +: PW]; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(bit cq, bit op, int q, int zs, bit ien, int bq);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_cq_i = cq; cfg_op_i = op; cfg_qid_i = 3'(q);
    cfg_zsize_i = 16'(zs); cfg_ien_i = ien; cfg_bind_i = 3'(bq);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic db(logic [15:0] a, logic [31:0] d);
    @(negedge clk_i);
    db_we_i = 1'b1; db_addr_i = a; db_wdata_i = d;
    @(negedge clk_i);
    db_we_i = 1'b0;
  endtask

  task automatic fetch(int q);
    @(negedge clk_i);
    sq_fetch_i = '0; sq_fetch_i[q] = 1'b1;
    @(negedge clk_i);
    sq_fetch_i = '0;
  endtask

  task automatic post(int cq, int sq, int st);
    @(negedge clk_i);
    cpl_post_i = 1'b1; cpl_cqid_i = 3'(cq); cpl_sqid_i = 3'(sq); cpl_status_i = 15'(st);
    @(negedge clk_i);
    cpl_post_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++;
      nvec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 sq_empty", 32'(sq_empty_o), 32'hFF);
    chk("R1 cq_full", 32'(cq_full_o), 0);
    chk("R1 phase", 32'(cq_phase_o), 0);
    chk("R1 pulses", {irq_req_o, restart_o, 7'd0, cpl_valid_o}, 0);
    chk("R1 ptrs", 32'(|{sq_head_o, sq_tail_o, cq_head_o, cq_tail_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 create all rings; SQ5 binds to CQ3
    for (int q = 0; q < NQ; q++) cfg(1, 1, q, 3, q[0], 0);
    for (int q = 0; q < NQ; q++) cfg(0, 1, q, 3, 0, (q == 5) ? 3 : q);
    chk("R2 phase after create", 32'(cq_phase_o), 32'hFF);
    chk("R2 cq_full after create", 32'(cq_full_o), 0);

    // R3 decode sweep over all pairs, upper data bits ignored
    for (int q = 0; q < NQ; q++) begin
      db(16'(16'h1000 + 8*q), 32'hABCD_0000 | 32'(q % 3 + 1));
      chk("R3 sq tail", 32'(sqt(q)), 32'(q % 3 + 1));
      chk("R3 sq not empty", 32'(sq_empty_o[q]), 0);
      chk("R3 cq head untouched", 32'(cqh(q)), 0);
    end

    // R4 misaligned
    for (int k = 1; k < 4; k++) begin
      db(16'(16'h1000 + k), 32'h0);
      chk("R4 misaligned sq0", 32'(sqt(0)), 1);
    end
    db(16'h1005, 32'h2);
    chk("R4 misaligned cq0", 32'(cqh(0)), 0);

    // R5 out of range / below region / value too big
    db(16'h1040, 32'h0);
    chk("R5 past last slot", 32'(sqt(0)), 1);
    db(16'h1044, 32'h2);
    chk("R5 past last slot cq", 32'(cqh(0)), 0);
    db(16'h0FF8, 32'h0);
    chk("R5 below region", 32'(sqt(0)), 1);
    db(16'h1000, 32'h4);
    chk("R5 value >= size", 32'(sqt(0)), 1);

    // R6 fetch on SQ2 (size 4, tail 3)
    for (int k = 1; k <= 3; k++) begin
      fetch(2);
      chk("R6 head step", 32'(sqh(2)), 32'(k));
      chk("R6 empty flag", 32'(sq_empty_o[2]), 32'(k == 3));
    end
    fetch(2);
    chk("R6 fetch when empty", 32'(sqh(2)), 3);
    db(16'h1010, 32'h1);
    fetch(2);
    chk("R6 head wrap", 32'(sqh(2)), 0);
    fetch(2);
    chk("R6 head after wrap", 32'(sqh(2)), 1);
    chk("R6 empty after wrap", 32'(sq_empty_o[2]), 1);

    // R11 irq enable: CQ1 enabled, CQ2 disabled
    for (int q = 1; q <= 2; q++) begin
      post(q, q, 7);
      post(q, q, 8);
      db(16'(16'h1004 + 8*q), 32'h1);
      chk("R11 irq when tail!=head", 32'(irq_req_o), (q == 1) ? 32'h2 : 32'h0);
      chk("R10 no restart when not full", 32'(restart_o), 0);
      db(16'(16'h1004 + 8*q), 32'h2);
      chk("R11 no irq when tail==head", 32'(irq_req_o), 0);
    end

    // R7 R8 R9 R10 R11 sweep on CQ3 over sizes 2..5
    for (int z = 1; z <= 4; z++) begin
      int s, mt, mh, mp;
      cfg(1, 1, 3, z, 1, 0);
      s = z + 1; mt = 0; mh = 0; mp = 1;
      for (int i = 0; i < 4*s; i++) begin
        bit full;
        full = (((mt + 1) % s) == mh);
        chk("R7 full flag", 32'(cq_full_o[3]), 32'(full));
        post(3, 5, i + 16*z);
        if (!full) begin
          chk("R9 cpl valid", 32'(cpl_valid_o), 1);
          chk("R9 cpl word", 32'(cpl_word_o), 32'(((i + 16*z) << 1) | mp));
          chk("R9 cpl slot", 32'(cpl_slot_o), 32'(mt));
          chk("R9 cpl sq", {13'd0, cpl_sqid_o, cpl_sqhead_o}, {13'd0, 3'd5, 16'd0});
          if (mt == s - 1) mp = 1 - mp;
          mt = (mt + 1) % s;
          chk("R8 tail", 32'(cqt(3)), 32'(mt));
          chk("R8 phase", 32'(cq_phase_o[3]), 32'(mp));
        end else begin
          int nh;
          chk("R7 post dropped", 32'(cpl_valid_o), 0);
          chk("R7 tail held", 32'(cqt(3)), 32'(mt));
          nh = (mh + 1) % s;
          db(16'h101C, 32'(nh));
          chk("R10 restart bound rings", 32'(restart_o), 32'h28);
          chk("R11 irq on free", 32'(irq_req_o), (mt != nh) ? 32'h8 : 32'h0);
          mh = nh;
          chk("R3 cq head", 32'(cqh(3)), 32'(mh));
        end
      end
    end

    // R2 zero size rejected: CQ6 keeps size 4
    cfg(1, 1, 6, 0, 0, 0);
    db(16'h1034, 32'h3);
    chk("R2 zsize 0 rejected", 32'(cqh(6)), 3);

    // R12 delete then doorbell ignored
    cfg(0, 0, 6, 0, 0, 0);
    db(16'h1030, 32'h2);
    chk("R12 deleted sq ignores db", 32'(sqt(6)), 1);
    cfg(1, 0, 7, 0, 0, 0);
    cfg(0, 1, 6, 3, 0, 7);
    db(16'h1030, 32'h2);
    chk("R2 bind to invalid cq rejected", 32'(sqt(6)), 1);
    cfg(0, 1, 6, 3, 0, 6);
    chk("R2 create clears tail", 32'(sqt(6)), 0);
    db(16'h1030, 32'h2);
    chk("R2 recreated sq accepts db", 32'(sqt(6)), 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule